// File: doc/BRIEF.md
# Frame Bank Address Sequencer

This block sits beside a video capture write engine and tells it where the next frame goes. Software loads up to eight bank base addresses and a mask of valid banks through a simple 32-bit register bus, then sets the capture enable. Each frame-end strobe from the datapath moves a bank pointer to the next valid bank. The pointer wraps to bank 0 after the highest valid bank. The selected bank's 64-bit base address, forced to 512-byte alignment, is presented to the write engine on a registered output.

The bank status field names the bank that the *upcoming* frame will be written to, not the one just completed. Software finds the finished frame by stepping back one bank, wrapping from 0 to the highest valid bank. Two events are latched in a status register and can each raise the interrupt line:
- a frame-end event;
- a capture-stopped event, which fires when the module-active flag drops after capture is disabled and the datapath has gone idle.

A software-reset bit returns the pointer to bank 0 and clears the event status. The stored bank addresses are left intact. All register reads return data one cycle after the read strobe.

Top module: `frame_bank_seq`

## Requirements
- R1: After synchronous reset, the bank pointer is 0, all event status and enable bits are 0, capture is disabled, `irq_o` is 0 and `bus_rdata` is 0.
- R2: Bank n's low address word is at offset 0x100+8n and reads back with bits 8:0 as zero. Bank n's high word is at 0x104+8n and reads back in full.
- R3: A frame-end strobe while capture is enabled moves the pointer from bank k to bank k+1 when mask bit k+1 is set. Otherwise, and after the last bank, the pointer wraps to bank 0.
- R4: While capture is disabled (bit 0 of offset 0x200 clear), a frame-end strobe changes neither the pointer nor the status register.
- R5: Bits 2:0 of offset 0x14C read the pointer, which is the destination bank of the next frame.
- R6: `dest_addr_o` equals {high word, low word with bits 8:0 zero} of the pointed bank, one cycle after the pointer or that bank's register changes.
- R7: Bit 17 of the status register at offset 0x008 sets on every enabled frame-end strobe. Writing 1 to it clears it, writing 0 leaves it, and a set in the same cycle as a clear wins.
- R8: The enable register at offset 0x004 holds the enables in bits 17 (frame end) and 16 (capture stopped). `irq_o` is 1 exactly one cycle after any status bit and its enable bit are both 1.
- R9: Bit 2 of offset 0x254 reads 1 while capture is enabled or `dp_busy_i` is high (one cycle late). Status bit 16 sets when that flag falls.
- R10: Writing 1 to bit 0 of offset 0x00C clears the pointer and all status bits. Bank addresses, mask, enables and capture enable keep their values.
- R11: The valid mask at offset 0x148 (bits 7:0) reads back as written, and a new mask governs the next pointer step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| frame_end_i | input | 1 | One-cycle frame-end strobe from the datapath |
| dp_busy_i | input | 1 | Datapath still has work in flight |
| dest_addr_o | output | 64 | Aligned base address of the destination bank |
| cap_en_o | output | 1 | Capture enable to the datapath |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the capture-stopped event. It needs the active flag to stay high after capture is disabled and then drop only when the datapath goes idle. The bench reaches it by holding `dp_busy_i` high across the write that clears the enable, then reading the active flag, and only then releasing `dp_busy_i`. A full lap of all eight banks, after a software reset mid-sequence, covers the wrap at the widest mask.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_IRQ_EN    = 12'h004;
  localparam logic [REG_AW-1:0] OFS_IRQ_STS   = 12'h008;
  localparam logic [REG_AW-1:0] OFS_SOFT_RST  = 12'h00C;
  localparam logic [REG_AW-1:0] OFS_BANK_BASE = 12'h100;
  localparam logic [REG_AW-1:0] OFS_VALID     = 12'h148;
  localparam logic [REG_AW-1:0] OFS_BANK_STAT = 12'h14C;
  localparam logic [REG_AW-1:0] OFS_CAP_EN    = 12'h200;
  localparam logic [REG_AW-1:0] OFS_MOD_STAT  = 12'h254;

  // event bits sit side by side starting at this position
  localparam int EVT_LSB = 16;
  localparam int NEVT    = 2;
  localparam int ACT_BIT = 2;

  typedef enum int {
    EV_STOP  = 0,
    EV_FRAME = 1
  } evt_e;
endpackage

// File: rtl/fbs_bank_store.sv
module fbs_bank_store #(
  parameter int NBANK      = 8,
  parameter int IW         = 3,
  parameter int ALIGN_BITS = 9,
  parameter int DW         = 32
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic            wr_hi,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [IW-1:0]   rd_idx_a,
  input  logic            rd_hi_a,
  output logic [DW-1:0]   rd_data_a,
  input  logic [IW-1:0]   rd_idx_b,
  output logic [2*DW-1:0] base_b
);
  localparam int LO_W = DW - ALIGN_BITS;

  logic [LO_W-1:0] lo_mem [NBANK];
  logic [DW-1:0]   hi_mem [NBANK];

  always_ff @(posedge clk) begin
    if (wr_en && !wr_hi) lo_mem[wr_idx] <= wr_data[DW-1:ALIGN_BITS];
    if (wr_en && wr_hi)  hi_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data_a <= rd_hi_a ? hi_mem[rd_idx_a] : {lo_mem[rd_idx_a], {ALIGN_BITS{1'b0}}};
    base_b    <= {hi_mem[rd_idx_b], lo_mem[rd_idx_b], {ALIGN_BITS{1'b0}}};
  end
endmodule

// File: rtl/fbs_bank_ptr.sv
module fbs_bank_ptr #(
  parameter int NBANK = 8,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [NBANK-1:0] valid_mask,
  output logic [IW-1:0]    idx_q
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NBANK - 1);

  logic [IW-1:0] idx_inc;
  logic [IW-1:0] idx_nxt;

  assign idx_inc = idx_q + 1'b1;

  always_comb begin
    if (idx_q == LAST_IDX)           idx_nxt = '0;
    else if (valid_mask[idx_inc])    idx_nxt = idx_inc;
    else                             idx_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  idx_q <= '0;
    else if (step)   idx_q <= idx_nxt;
  end
endmodule

// File: rtl/fbs_irq_ctrl.sv
module fbs_irq_ctrl #(
  parameter int NEVT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [NEVT-1:0] evt_set,
  input  logic            w1c_en,
  input  logic [NEVT-1:0] w1c_mask,
  input  logic            en_we,
  input  logic [NEVT-1:0] en_wdata,
  output logic [NEVT-1:0] sts_q,
  output logic [NEVT-1:0] en_q,
  output logic            irq_q
);
  for (genvar i = 0; i < NEVT; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst || clr)                   sts_q[i] <= 1'b0;
      else if (evt_set[i])              sts_q[i] <= 1'b1;
      else if (w1c_en && w1c_mask[i])   sts_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_wdata;
      irq_q <= |(sts_q & en_q);
    end
  end
endmodule

// File: rtl/frame_bank_seq.sv
module frame_bank_seq
  import fbs_pkg::*;
#(
  parameter int NBANK      = 8,
  parameter int ALIGN_BITS = 9,
  parameter int DW         = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              frame_end_i,
  input  logic              dp_busy_i,
  output logic [2*DW-1:0]   dest_addr_o,
  output logic              cap_en_o,
  output logic              irq_o
);
  localparam int IW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [REG_AW-1:0] BANK_SPAN = REG_AW'(8 * NBANK);

  logic              cap_en_q;
  logic [NBANK-1:0]  mask_q;
  logic              act_q;
  logic              act_nxt;
  logic              rd_bank_q;
  logic [DW-1:0]     misc_q;
  logic [DW-1:0]     misc_val;
  logic [DW-1:0]     store_rd;
  logic [IW-1:0]     bank_idx;
  logic [NEVT-1:0]   irq_sts;
  logic [NEVT-1:0]   irq_en;
  logic [NEVT-1:0]   evt_set;
  logic [REG_AW-1:0] bank_off;
  logic              bank_hit;
  logic [IW-1:0]     bank_sel;
  logic              bank_hi;
  logic              step;
  logic              soft_clr;
  logic              wr_ien, wr_sts, wr_mask, wr_cap;

  // register decode
  assign bank_off = bus_addr - OFS_BANK_BASE;
  assign bank_hit = (bus_addr >= OFS_BANK_BASE) && (bank_off < BANK_SPAN) &&
                    (bank_off[1:0] == 2'b00);
  assign bank_sel = bank_off[IW+2:3];
  assign bank_hi  = bank_off[2];

  assign wr_ien   = bus_wr && (bus_addr == OFS_IRQ_EN);
  assign wr_sts   = bus_wr && (bus_addr == OFS_IRQ_STS);
  assign wr_mask  = bus_wr && (bus_addr == OFS_VALID);
  assign wr_cap   = bus_wr && (bus_addr == OFS_CAP_EN);
  assign soft_clr = bus_wr && (bus_addr == OFS_SOFT_RST) && bus_wdata[0];

  assign step    = frame_end_i && cap_en_q;
  assign act_nxt = cap_en_q || dp_busy_i;

  always_comb begin
    evt_set           = '0;
    evt_set[EV_FRAME] = step;
    evt_set[EV_STOP]  = act_q && !act_nxt;
  end

  fbs_bank_store #(
    .NBANK(NBANK), .IW(IW), .ALIGN_BITS(ALIGN_BITS), .DW(DW)
  ) u_store (
    .clk       (clk),
    .wr_en     (bus_wr && bank_hit),
    .wr_hi     (bank_hi),
    .wr_idx    (bank_sel),
    .wr_data   (bus_wdata),
    .rd_idx_a  (bank_sel),
    .rd_hi_a   (bank_hi),
    .rd_data_a (store_rd),
    .rd_idx_b  (bank_idx),
    .base_b    (dest_addr_o)
  );

  fbs_bank_ptr #(.NBANK(NBANK), .IW(IW)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .clr        (soft_clr),
    .step       (step),
    .valid_mask (mask_q),
    .idx_q      (bank_idx)
  );

  fbs_irq_ctrl #(.NEVT(NEVT)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .clr      (soft_clr),
    .evt_set  (evt_set),
    .w1c_en   (wr_sts),
    .w1c_mask (bus_wdata[EVT_LSB +: NEVT]),
    .en_we    (wr_ien),
    .en_wdata (bus_wdata[EVT_LSB +: NEVT]),
    .sts_q    (irq_sts),
    .en_q     (irq_en),
    .irq_q    (irq_o)
  );

  // readback of the non-bank registers
  always_comb begin
    misc_val = '0;
    case (bus_addr)
      OFS_IRQ_EN:    misc_val[EVT_LSB +: NEVT] = irq_en;
      OFS_IRQ_STS:   misc_val[EVT_LSB +: NEVT] = irq_sts;
      OFS_VALID:     misc_val[NBANK-1:0]       = mask_q;
      OFS_BANK_STAT: misc_val[IW-1:0]          = bank_idx;
      OFS_CAP_EN:    misc_val[0]               = cap_en_q;
      OFS_MOD_STAT:  misc_val[ACT_BIT]         = act_q;
      default:       misc_val                  = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en_q  <= 1'b0;
      mask_q    <= '0;
      act_q     <= 1'b0;
      rd_bank_q <= 1'b0;
      misc_q    <= '0;
    end else begin
      if (wr_cap)  cap_en_q <= bus_wdata[0];
      if (wr_mask) mask_q   <= bus_wdata[NBANK-1:0];
      act_q <= act_nxt;
      if (bus_rd) begin
        rd_bank_q <= bank_hit;
        misc_q    <= bank_hit ? '0 : misc_val;
      end
    end
  end

  assign bus_rdata = rd_bank_q ? store_rd : misc_q;
  assign cap_en_o  = cap_en_q;
endmodule

// File: rtl/frame_bank_seq_chk.sv
module frame_bank_seq_chk #(
  parameter int NBANK      = 8,
  parameter int IW         = 3,
  parameter int ALIGN_BITS = 9,
  parameter int NEVT       = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            step,
  input logic            soft_clr,
  input logic [IW-1:0]   idx,
  input logic [NEVT-1:0] sts,
  input logic [NEVT-1:0] en,
  input logic            irq,
  input logic [63:0]     dest
);
  // R4: without an enabled strobe or soft reset the pointer holds
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!step && !soft_clr) |=> $stable(idx));

  // R3: an enabled strobe moves one bank up or wraps to 0
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !soft_clr) |=> ((idx == '0) || (idx == IW'($past(idx) + 1'b1))));

  // R10: soft reset clears pointer and status
  assert_soft_clr_R10: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> ((idx == '0) && (sts == '0)));

  // R8: interrupt follows enabled status by one cycle
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(sts & en))));

  // R7: enabled strobe leaves the frame-end status set
  assert_frame_sts_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !soft_clr) |=> sts[1]);

  // R6: output address always aligned
  assert_dest_align_R6: assert property (@(posedge clk) disable iff (rst)
    dest[ALIGN_BITS-1:0] == '0);
endmodule

bind frame_bank_seq frame_bank_seq_chk #(
  .NBANK(NBANK), .IW(IW), .ALIGN_BITS(ALIGN_BITS), .NEVT(fbs_pkg::NEVT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .step     (step),
  .soft_clr (soft_clr),
  .idx      (bank_idx),
  .sts      (irq_sts),
  .en       (irq_en),
  .irq      (irq_o),
  .dest     (dest_addr_o)
);

// File: tb/frame_bank_seq_test.sv
module frame_bank_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_end_i = 1'b0;
  logic        dp_busy_i = 1'b0;
  logic [63:0] dest_addr_o;
  logic        cap_en_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frame_bank_seq uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_end_i(frame_end_i),
    .dp_busy_i(dp_busy_i), .dest_addr_o(dest_addr_o), .cap_en_o(cap_en_o), .irq_o(irq_o)
  );

  // {op, req, addr, data, expected}; op 0 write, 1 read+compare, 2 frame strobe
  localparam int NV = 35;
  localparam logic [81:0] TBL [NV] = '{
    {2'd0, 4'd2,  12'h100, 32'h100001FF, 32'h0},
    {2'd0, 4'd2,  12'h104, 32'h000000A0, 32'h0},
    {2'd0, 4'd2,  12'h108, 32'h10001000, 32'h0},
    {2'd0, 4'd2,  12'h10C, 32'h000000A1, 32'h0},
    {2'd0, 4'd2,  12'h110, 32'h10002000, 32'h0},
    {2'd0, 4'd2,  12'h114, 32'h000000A2, 32'h0},
    {2'd1, 4'd2,  12'h100, 32'h0, 32'h10000000},  // R2 low bits dropped
    {2'd1, 4'd2,  12'h10C, 32'h0, 32'h000000A1},  // R2 high word
    {2'd0, 4'd11, 12'h148, 32'h7, 32'h0},
    {2'd1, 4'd11, 12'h148, 32'h0, 32'h7},         // R11 readback
    {2'd0, 4'd8,  12'h004, 32'h00020000, 32'h0},
    {2'd2, 4'd4,  12'h000, 32'h0, 32'h0},         // R4 strobe while disabled
    {2'd1, 4'd4,  12'h14C, 32'h0, 32'h0},
    {2'd1, 4'd4,  12'h008, 32'h0, 32'h0},
    {2'd0, 4'd9,  12'h200, 32'h1, 32'h0},
    {2'd1, 4'd9,  12'h200, 32'h0, 32'h1},
    {2'd1, 4'd9,  12'h254, 32'h0, 32'h4},         // R9 active flag
    {2'd2, 4'd3,  12'h000, 32'h0, 32'h0},
    {2'd1, 4'd5,  12'h14C, 32'h0, 32'h1},         // R5 next destination
    {2'd1, 4'd7,  12'h008, 32'h0, 32'h00020000},  // R7 set
    {2'd0, 4'd7,  12'h008, 32'h0, 32'h0},
    {2'd1, 4'd7,  12'h008, 32'h0, 32'h00020000},  // R7 write 0 ignored
    {2'd0, 4'd7,  12'h008, 32'h00020000, 32'h0},
    {2'd1, 4'd7,  12'h008, 32'h0, 32'h0},         // R7 cleared
    {2'd2, 4'd3,  12'h000, 32'h0, 32'h0},
    {2'd1, 4'd3,  12'h14C, 32'h0, 32'h2},         // R3 step
    {2'd2, 4'd3,  12'h000, 32'h0, 32'h0},
    {2'd1, 4'd3,  12'h14C, 32'h0, 32'h0},         // R3 wrap after highest
    {2'd0, 4'd11, 12'h148, 32'h1, 32'h0},
    {2'd2, 4'd11, 12'h000, 32'h0, 32'h0},
    {2'd1, 4'd11, 12'h14C, 32'h0, 32'h0},         // R11 single bank
    {2'd0, 4'd11, 12'h148, 32'h3, 32'h0},
    {2'd2, 4'd11, 12'h000, 32'h0, 32'h0},
    {2'd1, 4'd11, 12'h14C, 32'h0, 32'h1},         // R11 new mask used
    {2'd1, 4'd8,  12'h004, 32'h0, 32'h00020000}   // R8 enable readback
  };

  task automatic chk(input int req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic strobe();
    @(negedge clk);
    frame_end_i = 1'b1;
    @(negedge clk);
    frame_end_i = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1: watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(1, irq_o, 0);
    chk(1, cap_en_o, 0);
    chk(1, bus_rdata, 0);
    rd(12'h14C, d); chk(1, d, 0);
    rd(12'h008, d); chk(1, d, 0);
    rd(12'h004, d); chk(1, d, 0);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i][81:80])
        2'd0: wr(TBL[i][75:64], TBL[i][63:32]);
        2'd1: begin rd(TBL[i][75:64], d); chk(int'(TBL[i][79:76]), d, TBL[i][31:0]); end
        default: strobe();
      endcase
    end

    // R8: status still set from table strobes, enabled -> irq high
    @(negedge clk);
    chk(8, irq_o, 1);
    wr(12'h004, 32'h0);
    @(negedge clk);
    chk(8, irq_o, 0);
    wr(12'h004, 32'h00020000);
    @(negedge clk);
    chk(8, irq_o, 1);

    // R6: pointer is 1 -> bank 1 address
    chk(6, dest_addr_o, 64'h000000A1_10001000);
    strobe();
    @(negedge clk);
    chk(6, dest_addr_o, 64'h000000A0_10000000);

    // R10: soft reset clears pointer and status, keeps banks and mask
    strobe();
    wr(12'h00C, 32'h1);
    rd(12'h14C, d); chk(10, d, 0);
    rd(12'h008, d); chk(10, d, 0);
    rd(12'h100, d); chk(10, d, 32'h10000000);
    rd(12'h148, d); chk(10, d, 32'h3);
    chk(10, irq_o, 0);

    // R9: stop event once datapath goes idle after disable
    wr(12'h004, 32'h00030000);
    dp_busy_i = 1'b1;
    wr(12'h200, 32'h0);
    strobe();
    rd(12'h14C, d); chk(4, d, 0);
    rd(12'h254, d); chk(9, d, 32'h4);
    rd(12'h008, d); chk(9, d, 0);
    dp_busy_i = 1'b0;
    repeat (2) @(negedge clk);
    rd(12'h254, d); chk(9, d, 0);
    rd(12'h008, d); chk(9, d, 32'h00010000);
    chk(8, irq_o, 1);

    // R3: full lap with all eight banks
    wr(12'h148, 32'hFF);
    wr(12'h200, 32'h1);
    wr(12'h00C, 32'h1);
    for (int k = 0; k < 9; k++) begin
      strobe();
      rd(12'h14C, d);
      chk(3, d, 32'((k + 1) % 8));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule